// File: doc/BRIEF.md
# SMBus Register-Access Slave

This block lets an SMBus or I2C master read and write a small bank of byte registers. It oversamples the bus clock and data lines on the system clock, detects START and STOP conditions, and answers only to the 7-bit device address `0x28`. It drives the data line low through an open-drain enable, both to acknowledge and to send read data. Clock stretching is not used, and the oversampling keeps up with any SCL rate from 10 kHz to 400 kHz as long as the system clock is much faster.

A byte pointer selects the register for every access. Four transaction types work on this pointer. Write Byte sets the pointer and stores data. Send Byte only sets the pointer. Read Byte sets the pointer, issues a repeated START, then reads. Receive Byte reads at the current pointer. The pointer advances after every data byte, so a master can stream any number of bytes in either direction, in plain I2C style with no byte count. An external monitor for bus timeouts or idle time can force the slave back to idle at any bit through a synchronous abort input.

Top module: `smbus_reg_slave`

## Requirements
- R1: After reset, `sda_oe` is low, every register holds 0x00 and the pointer is 0, so a Receive Byte returns 0x00.
- R2: An address byte whose upper seven bits are not 0x28 gets no ACK. The slave then leaves `sda_oe` low and changes no state until the next START or STOP.
- R3: In a Write Byte (address byte 0x50, register byte, data byte), the slave drives ACK low after each of the three bytes and stores the data byte in the addressed register.
- R4: A Send Byte (address byte 0x50 followed by one byte, then STOP) loads the pointer only. A following Receive Byte (address byte 0x51) returns the register it names.
- R5: A START seen mid-transaction, including in the middle of a byte, restarts address reception. This makes Read Byte work: write the register number, repeated START, address byte 0x51, and the register is shifted out MSB first.
- R6: The pointer increments after every data byte written or read, so multi-byte writes and reads access consecutive registers.
- R7: After the master NACKs a read byte, the slave releases SDA and drives nothing until START or STOP.
- R8: A STOP at any point returns the slave to idle with SDA released, and any partly received byte is discarded.
- R9: A high `bus_abort` on a clock edge releases SDA from the next cycle and returns the slave to idle. Register contents and the pointer are kept.
- R10: `sda_oe` changes only while the synchronized SCL is low, except when a release is forced by START, STOP or abort.
- R11: The register number is taken modulo the register count (16 by default), so register 0x13 aliases register 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_abort | input | 1 | Synchronous abort request from an external timeout or idle monitor |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull the data line low when high (open-drain enable) |

## Verification
The assertions check, on every cycle, that START, STOP and abort release the data line on the next cycle, that nothing is driven while the slave ignores the bus, and that the drive enable moves only while the synchronized clock is low. Only the bench's bus scenarios show that data lands in the right register: each transaction type, pointer auto-increment, register aliasing, the discarded partial byte after a STOP, a restart in mid-byte, and that the pointer survives an abort.

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h28,
  parameter int         DEPTH    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_abort,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int IW = $clog2(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REG, S_WR, S_ACK, S_RD, S_RACK, S_WAIT} st_t;

  st_t        st, nxt;
  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;
  logic [7:0] sr, tx, ptr;
  logic [3:0] cnt;
  logic [7:0] regs [DEPTH];

  logic scl_s, sda_s, start_c, stop_c, scl_rise, scl_fall, in_wait;
  logic [IW-1:0] idx;

  assign scl_s    = scl_q[1];
  assign sda_s    = sda_q[1];
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign idx      = ptr[IW-1:0];
  assign in_wait  = (st == S_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 2'b11;
      sda_q  <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      st     <= S_IDLE;
      nxt    <= S_IDLE;
      sr     <= '0;
      tx     <= '0;
      ptr    <= '0;
      cnt    <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
      if (bus_abort || stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_REG, S_WR: begin
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (st)
                S_ADDR: begin
                  if (sr[7:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1;
                    st     <= S_ACK;
                    nxt    <= sr[0] ? S_RD : S_REG;
                  end else begin
                    st <= S_WAIT;
                  end
                end
                S_REG: begin
                  ptr    <= sr;
                  sda_oe <= 1'b1;
                  st     <= S_ACK;
                  nxt    <= S_WR;
                end
                default: begin
                  regs[idx] <= sr;
                  ptr       <= ptr + 8'd1;
                  sda_oe    <= 1'b1;
                  st        <= S_ACK;
                  nxt       <= S_WR;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              st  <= nxt;
              if (nxt == S_RD) begin
                tx     <= regs[idx];
                sda_oe <= ~regs[idx][7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          S_RD: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 8'd1;
                st     <= S_RACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                st <= S_WAIT;
              end else begin
                st  <= S_ACK;
                nxt <= S_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbus_reg_slave_chk.sv
module smbus_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_abort,
  input logic sda_oe,
  input logic scl_s,
  input logic start_c,
  input logic stop_c,
  input logic in_wait
);
  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |=> !sda_oe); // R9
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe); // R8
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_oe); // R5
  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !sda_oe); // R2, R7
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R10
  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !$past(bus_abort) && !$past(stop_c) && !$past(start_c)) |-> !scl_s); // R10
endmodule

bind smbus_reg_slave smbus_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_abort(bus_abort), .sda_oe(sda_oe),
  .scl_s(scl_s), .start_c(start_c), .stop_c(stop_c), .in_wait(in_wait)
);

// File: tb/smbus_reg_slave_tb.sv
module smbus_reg_slave_tb;
  localparam int Q = 16;

  logic clk = 1'b0, rst_n = 1'b0, bus_abort = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  smbus_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_abort(bus_abort),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int    exp_q[$];
  string tag_q[$];
  int    act_q[$];
  int    n_cmp = 0, n_bad = 0;
  int    oe_cnt = 0, oe_bad = 0;
  logic  oe_d = 1'b0;

  always @(negedge clk) begin
    if (sda_oe) oe_cnt++;
    if (sda_oe !== oe_d && scl_m) oe_bad++;
    oe_d = sda_oe;
  end

  always @(posedge clk) begin : mon
    int e, a;
    string t;
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = act_q.pop_front();
      n_cmp++;
      if (a != e) begin
        n_bad++;
        $display("FAIL %s: got %0h expected %0h", t, a, e);
      end
    end
  end

  task automatic chk(input string t, input int a, input int e);
    exp_q.push_back(e);
    tag_q.push_back(t);
    act_q.push_back(a);
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); b = sda_line; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic wbits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) wbit(v[i]);
  endtask

  task automatic wr(input logic [7:0] v, input logic ack_e, input string t);
    logic a;
    wbits(v, 8);
    rbit(a);
    chk(t, a, ack_e);
  endtask

  task automatic rd(input logic [7:0] e, input logic mack, input string t);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    chk(t, v, e);
    wbit(mack);
  endtask

  task automatic wreg(input logic [7:0] r, input logic [7:0] d);
    bus_start();
    wr(8'h50, 1'b0, "R3 address ack");
    wr(r, 1'b0, "R3 register ack");
    wr(d, 1'b0, "R3 data ack");
    bus_stop();
  endtask

  task automatic rreg(input logic [7:0] r, input logic [7:0] e, input string t);
    bus_start();
    wr(8'h50, 1'b0, t);
    wr(r, 1'b0, t);
    bus_start();
    wr(8'h51, 1'b0, t);
    rd(e, 1'b1, t);
    bus_stop();
  endtask

  task automatic rcv(input logic [7:0] e, input string t);
    bus_start();
    wr(8'h51, 1'b0, t);
    rd(e, 1'b1, t);
    bus_stop();
  endtask

  task automatic fin();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    fin();
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    chk("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    hq();
    rcv(8'h00, "R1 register 0 after reset");

    wreg(8'h03, 8'hA5);
    rreg(8'h03, 8'hA5, "R5 read byte");

    bus_start();
    wr(8'h50, 1'b0, "R7 setup");
    wr(8'h03, 1'b0, "R7 setup");
    bus_start();
    wr(8'h51, 1'b0, "R7 setup");
    rd(8'hA5, 1'b1, "R7 data before NACK");
    base = oe_cnt;
    rd(8'hFF, 1'b1, "R7 bus released after NACK");
    chk("R7 no drive after NACK", oe_cnt - base, 0);
    bus_stop();

    wreg(8'h07, 8'h3C);
    bus_start();
    wr(8'h50, 1'b0, "R4 send byte address ack");
    wr(8'h03, 1'b0, "R4 send byte ack");
    bus_stop();
    rcv(8'hA5, "R4 receive at pointer");
    rcv(8'h00, "R4 receive advanced pointer");

    bus_start();
    wr(8'h50, 1'b0, "R6 address ack");
    wr(8'h0A, 1'b0, "R6 register ack");
    wr(8'h11, 1'b0, "R6 data ack 1");
    wr(8'h22, 1'b0, "R6 data ack 2");
    wr(8'h33, 1'b0, "R6 data ack 3");
    bus_stop();
    bus_start();
    wr(8'h50, 1'b0, "R6 setup");
    wr(8'h0A, 1'b0, "R6 setup");
    bus_start();
    wr(8'h51, 1'b0, "R6 setup");
    rd(8'h11, 1'b0, "R6 sequential read 1");
    rd(8'h22, 1'b0, "R6 sequential read 2");
    rd(8'h33, 1'b1, "R6 sequential read 3");
    bus_stop();
    rcv(8'h00, "R6 pointer past last read");

    wreg(8'h13, 8'h77);
    rreg(8'h03, 8'h77, "R11 register number aliases");

    bus_start();
    wr(8'h52, 1'b1, "R2 no ack for foreign address");
    base = oe_cnt;
    wr(8'h03, 1'b1, "R2 ignored byte 1");
    wr(8'h99, 1'b1, "R2 ignored byte 2");
    chk("R2 no drive after mismatch", oe_cnt - base, 0);
    bus_stop();
    rreg(8'h03, 8'h77, "R2 register unchanged");

    bus_start();
    wr(8'h50, 1'b0, "R8 setup");
    wr(8'h04, 1'b0, "R8 setup");
    wbits(8'hF0, 4);
    bus_stop();
    rreg(8'h04, 8'h00, "R8 partial byte dropped");

    wreg(8'h06, 8'h5A);
    bus_start();
    wr(8'h50, 1'b0, "R5 setup");
    wr(8'h06, 1'b0, "R5 setup");
    wbits(8'h00, 3);
    bus_start();
    wr(8'h51, 1'b0, "R5 restart address ack");
    rd(8'h5A, 1'b1, "R5 restart mid byte");
    bus_stop();

    wreg(8'h05, 8'h4E);
    bus_start();
    wr(8'h50, 1'b0, "R9 setup");
    wr(8'h05, 1'b0, "R9 setup");
    bus_start();
    wr(8'h51, 1'b0, "R9 setup");
    chk("R9 driving before abort", sda_oe, 1);
    bus_abort = 1'b1;
    @(negedge clk);
    bus_abort = 1'b0;
    chk("R9 released after abort", sda_oe, 0);
    rd(8'hFF, 1'b1, "R9 bus ignored after abort");
    bus_stop();
    rcv(8'h4E, "R9 pointer and register kept");

    chk("R10 enable changes only with SCL low", oe_bad, 0);
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    fin();
  end
endmodule